// File: doc/BRIEF.md
# Shared Shutdown-Pin Temperature and Overvoltage Monitor

This block watches a single external sense pin that serves two protections: overtemperature, sensed through a thermistor, and auxiliary overvoltage. The block splits time into windows of a fixed number of switching cycles. In each window the pin is biased one of two ways, and consecutive windows alternate between the two. During a temperature window an internal current source of about 107 µA drives the pin, so a hot thermistor (low resistance) pulls the pin voltage down. During an overvoltage window the pin goes through an internal resistor of about 8.33 kΩ to ground, so an external divider raises the pin only when the monitored voltage is too high.

An analog comparator outside the block compares the pin with a reference. The block reads the comparator result only at the strobe that closes the final cycle of a window, which gives the bias time to settle. A temperature fault is a pin below the reference. An overvoltage fault is a pin above it. The block also chooses the reference level: the higher level applies while the start-up flag is set and the lower level applies otherwise. Each fault is sent to the supervisor as a one-clock pulse.

Top module: `sdpin_fault_monitor`

## Requirements
- R1: Synchronous reset (`rst`=1) puts the block in a temperature window at cycle 0. After reset, `bias_src_sel`=1, `otp_fault`=0, `ovp_fault`=0 and `thr_hi`=0.
- R2: Each window lasts CYC_PER_WIN strobes of `cyc_stb` (default 4). The windows alternate, starting with a temperature window. `bias_src_sel` is 1 (current source) in a temperature window and 0 (pull-down resistor) in an overvoltage window.
- R3: `bias_src_sel` changes only in the clock after an edge at which the strobe that closes a window is sampled. At all other times it holds its value.
- R4: `cmp_above` is ignored on every clock except the edge at which the strobe that closes a window is sampled. At any other time it raises no fault.
- R5: When a temperature window closes with `cmp_above`=0, `otp_fault` goes high in the following clock.
- R6: When an overvoltage window closes with `cmp_above`=1, `ovp_fault` goes high in the following clock.
- R7: Each fault output is a single-cycle pulse. The two fault outputs are never high together.
- R8: `thr_hi` follows `startup` one clock later. A value of 1 selects the 1.2 V reference and 0 selects the 1.0 V reference.
- R9: When `cyc_stb` is low, the window position stays where it is for any number of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | One-clock pulse that ends a switching cycle |
| cmp_above | input | 1 | Comparator result: the pin is above the selected reference |
| startup | input | 1 | The converter is in its start-up phase |
| bias_src_sel | output | 1 | 1 = current source on the pin, 0 = resistor to ground |
| thr_hi | output | 1 | 1 = 1.2 V reference, 0 = 1.0 V reference |
| otp_fault | output | 1 | Overtemperature fault pulse |
| ovp_fault | output | 1 | Overvoltage fault pulse |

## Verification
A fault pulse and the bias select flip are both due in the clock right after the rising edge that samples the window-closing strobe. The reference select is due one clock after `startup` changes. The bench sets inputs at the falling edge and advances its reference model with the state that the next rising edge will see. It then compares every output at the falling edge that follows, so each expected value lines up with the single register stage in front of that output.

// File: rtl/sdmon_pkg.sv
package sdmon_pkg;

  // Which protection the pin is currently biased for.
  typedef enum logic {
    WIN_TEMP = 1'b0,
    WIN_VOLT = 1'b1
  } win_e;

  function automatic win_e next_win(input win_e w);
    return (w == WIN_TEMP) ? WIN_VOLT : WIN_TEMP;
  endfunction

  // The temperature window uses the current source, the voltage window the resistor.
  function automatic logic src_for(input win_e w);
    return (w == WIN_TEMP);
  endfunction

endpackage

// File: rtl/sdmon_window_seq.sv
module sdmon_window_seq
  import sdmon_pkg::*;
#(
  parameter int CYC_PER_WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_stb,
  output win_e win,
  output logic win_end,
  output logic src_sel
);

  logic last_cyc;

  generate
    if (CYC_PER_WIN <= 1) begin : g_single
      assign last_cyc = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(CYC_PER_WIN);
      localparam logic [CW-1:0] LAST = CW'(CYC_PER_WIN - 1);
      logic [CW-1:0] cyc_idx;

      always_ff @(posedge clk) begin
        if (rst) begin
          cyc_idx <= '0;
        end else if (cyc_stb) begin
          cyc_idx <= (cyc_idx == LAST) ? '0 : cyc_idx + 1'b1;
        end
      end

      assign last_cyc = (cyc_idx == LAST);
    end
  endgenerate

  assign win_end = cyc_stb & last_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      win     <= WIN_TEMP;
      src_sel <= src_for(WIN_TEMP);
    end else if (win_end) begin
      win     <= next_win(win);
      src_sel <= src_for(next_win(win));
    end
  end

endmodule

// File: rtl/sdmon_fault_eval.sv
module sdmon_fault_eval
  import sdmon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic win_end,
  input  win_e win,
  input  logic cmp_above,
  output logic otp_fault,
  output logic ovp_fault
);

  // Opposite polarity: a hot thermistor pulls the pin low, an overvoltage pushes it high.
  logic temp_bad, volt_bad;
  assign temp_bad = win_end && (win == WIN_TEMP) && !cmp_above;
  assign volt_bad = win_end && (win == WIN_VOLT) &&  cmp_above;

  always_ff @(posedge clk) begin
    if (rst) begin
      otp_fault <= 1'b0;
      ovp_fault <= 1'b0;
    end else begin
      otp_fault <= temp_bad;
      ovp_fault <= volt_bad;
    end
  end

endmodule

// File: rtl/sdmon_thr_sel.sv
module sdmon_thr_sel (
  input  logic clk,
  input  logic rst,
  input  logic startup,
  output logic thr_hi
);

  always_ff @(posedge clk) begin
    if (rst) thr_hi <= 1'b0;
    else     thr_hi <= startup;
  end

endmodule

// File: rtl/sdpin_fault_monitor.sv
module sdpin_fault_monitor
  import sdmon_pkg::*;
#(
  parameter int CYC_PER_WIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_stb,
  input  logic cmp_above,
  input  logic startup,
  output logic bias_src_sel,
  output logic thr_hi,
  output logic otp_fault,
  output logic ovp_fault
);

  win_e win;
  logic win_end;

  sdmon_window_seq #(.CYC_PER_WIN(CYC_PER_WIN)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .cyc_stb (cyc_stb),
    .win     (win),
    .win_end (win_end),
    .src_sel (bias_src_sel)
  );

  sdmon_fault_eval eval_i (
    .clk       (clk),
    .rst       (rst),
    .win_end   (win_end),
    .win       (win),
    .cmp_above (cmp_above),
    .otp_fault (otp_fault),
    .ovp_fault (ovp_fault)
  );

  sdmon_thr_sel thr_i (
    .clk     (clk),
    .rst     (rst),
    .startup (startup),
    .thr_hi  (thr_hi)
  );

endmodule

// File: rtl/sdmon_checker.sv
module sdmon_checker (
  input logic clk,
  input logic rst,
  input logic cyc_stb,
  input logic cmp_above,
  input logic startup,
  input logic bias_src_sel,
  input logic thr_hi,
  input logic otp_fault,
  input logic ovp_fault
);

  a_r7_otp_pulse: assert property (@(posedge clk) disable iff (rst)
    otp_fault |=> !otp_fault);

  a_r7_ovp_pulse: assert property (@(posedge clk) disable iff (rst)
    ovp_fault |=> !ovp_fault);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(otp_fault && ovp_fault));

  a_r3_src_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(cyc_stb) |-> $stable(bias_src_sel));

  a_r5_otp_cause: assert property (@(posedge clk) disable iff (rst)
    otp_fault |-> ($past(cyc_stb) && !$past(cmp_above) && $past(bias_src_sel) && !bias_src_sel));

  a_r6_ovp_cause: assert property (@(posedge clk) disable iff (rst)
    ovp_fault |-> ($past(cyc_stb) && $past(cmp_above) && !$past(bias_src_sel) && bias_src_sel));

  a_r8_thr_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (thr_hi == $past(startup)));

endmodule

bind sdpin_fault_monitor sdmon_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .cyc_stb      (cyc_stb),
  .cmp_above    (cmp_above),
  .startup      (startup),
  .bias_src_sel (bias_src_sel),
  .thr_hi       (thr_hi),
  .otp_fault    (otp_fault),
  .ovp_fault    (ovp_fault)
);

// File: tb/sdpin_fault_monitor_tb.sv
module sdpin_fault_monitor_tb_top;

  localparam int NWIN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_stb = 1'b0, cmp_above = 1'b0, startup = 1'b0;
  logic bias_src_sel, thr_hi, otp_fault, ovp_fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  int  m_idx;
  bit  m_volt;
  bit  e_otp, e_ovp, e_thr;

  always #10 clk = ~clk;

  sdpin_fault_monitor #(.CYC_PER_WIN(NWIN)) dut_i (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .cmp_above(cmp_above),
    .startup(startup), .bias_src_sel(bias_src_sel), .thr_hi(thr_hi),
    .otp_fault(otp_fault), .ovp_fault(ovp_fault)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_src();
    return !m_volt;
  endfunction

  // Called at a falling edge: drive, advance model across the next rising edge, compare.
  task automatic cyc(input bit stb, input bit cmp, input bit su, input string tag);
    bit closing;
    cyc_stb = stb; cmp_above = cmp; startup = su;
    closing = stb && (m_idx == NWIN - 1);
    e_otp = closing && !m_volt && !cmp;
    e_ovp = closing &&  m_volt &&  cmp;
    e_thr = su;
    if (stb) begin
      if (closing) begin m_idx = 0; m_volt = !m_volt; end
      else m_idx++;
    end
    @(posedge clk);
    @(negedge clk);
    chk(bias_src_sel, exp_src(), {tag, " src"});
    chk(otp_fault, e_otp, {tag, " otp R5"});
    chk(ovp_fault, e_ovp, {tag, " ovp R6"});
    chk(thr_hi, e_thr, {tag, " thr R8"});
    chk(!(otp_fault && ovp_fault), 1'b1, "R7 both faults");
  endtask

  initial begin
    void'($urandom(32'd1710));
    @(negedge clk);
    rst = 1'b1; cyc_stb = 1'b1; startup = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; cyc_stb = 1'b0; startup = 1'b0;
    m_idx = 0; m_volt = 1'b0;
    // R1 reset state
    chk(bias_src_sel, 1'b1, "R1 src");
    chk(otp_fault, 1'b0, "R1 otp");
    chk(ovp_fault, 1'b0, "R1 ovp");
    chk(thr_hi, 1'b0, "R1 thr");

    // Temperature window: high at early strobes, low at closing strobe -> R5
    for (int i = 0; i < NWIN; i++) begin
      cyc(1'b0, 1'b0, 1'b0, "R4");
      cyc(1'b1, (i == NWIN - 1) ? 1'b0 : 1'b1, 1'b0, "R5");
    end
    // Voltage window: low at early strobes, high between strobes, high at close -> R6
    for (int i = 0; i < NWIN; i++) begin
      cyc(1'b0, 1'b1, 1'b0, "R4");
      cyc(1'b1, (i == NWIN - 1) ? 1'b1 : 1'b0, 1'b0, "R6");
    end
    // No-fault closings: temp closes high, volt closes low -> R4
    for (int i = 0; i < 2 * NWIN; i++) cyc(1'b1, (i < NWIN), 1'b0, "R4");
    // Long gap without strobes -> R9
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'($urandom), 1'b0, "R9");
    // Back-to-back strobes with start-up toggling -> R2, R8
    for (int i = 0; i < 3 * NWIN; i++) cyc(1'b1, 1'($urandom), (i % 3) == 0, "R2 R8");
    // Random mix
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 3) == 0, 1'($urandom), ($urandom % 16) < 3, "R2 R3 R7");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule